// File: doc/BRIEF.md
# Unlockable Watchdog Timer

This peripheral restarts the system unless software keeps proving it is alive. A free-running counter advances on the bus clock or on a slow low-power tick. When the counter reaches a programmed timeout, the block raises a one-cycle reset request and latches an expiry flag. Software holds this off by writing refresh commands to the counter register. These commands are magic values, either as one 32-bit word or as a pair of 16-bit words. A control bit chooses which form the block decodes.

The configuration registers are protected. Software first writes an unlock command. It then polls the unlocked status bit and has a short window of bus clocks in which to rewrite the control/status, timeout and window registers. Writing control/status applies the new settings and closes the window. A reconfiguration-done status bit tells software that the new settings have taken effect. If the window register is nonzero, refresh is windowed: a refresh that arrives before the counter reaches the window value counts as a fault. An unlock attempt made after software has cleared the update-allowed bit is also a fault.

Top module: `wdt_core`

## Requirements
- R1: After reset, the reads are: control/status 0x00002020 (32-bit commands selected at bit 13, updates allowed at bit 5, every other bit 0); timeout `TMO_RST` (default 1000); counter 0; window 0. The reset request is low.
- R2: While bit 13 is 1, one write of 0xD928C520 to the counter register unlocks the block, and one write of 0xB480A602 clears the counter to 0. Other values written there have no effect.
- R3: While bit 13 is 0, only the low 16 bits of a counter write are decoded. 0xC520 followed by 0xD928 unlocks; 0xA602 followed by 0xB480 refreshes. The second word must land no more than 16 bus clocks after the first. A wrong word or a late word abandons the pair, and a wrong word that is itself a valid first word starts a new pair.
- R4: An accepted unlock opens a window of 255 bus clocks, during which bit 11 reads 1. Writes to control/status, timeout or window outside the window leave those registers unchanged. The one exception is the flag clear of R11.
- R5: A control/status write inside the window applies the new fields, sets bit 10, clears bit 11 and restarts the counter from 0. The next accepted unlock clears bit 10.
- R6: The control/status fields are: bit 7 count enable; bit 5 update allowed; bits 9:8 clock select; bit 13 command width (1 = 32-bit); bit 10 reconfiguration done; bit 11 unlocked; bit 14 flag.
- R7: While enabled, a clock select of 0 advances the counter on every bus clock. A nonzero clock select advances it only in cycles where `lpTick` is high.
- R8: A count step taken while the counter equals the timeout raises `resetReq` for exactly the next cycle, sets the flag and returns the counter to 0.
- R9: When the window register is nonzero and counting is enabled, a refresh accepted while the counter is below the window value still clears the counter, but also raises `resetReq` and sets the flag. A window of 0 accepts a refresh at any count.
- R10: An unlock command received while update-allowed is 0 raises `resetReq` and sets the flag. The block stays locked.
- R11: Writing 1 to bit 14 of control/status clears the flag whether or not the block is unlocked. If the flag is set in the same cycle, setting wins.
- R12: A valid refresh that lands on the count step that would expire the timer wins: no reset request, and the counter restarts from 0.
- R13: Register addresses: 0 control/status, 1 counter (reads the count value), 2 timeout, 3 window. Reads are combinational on `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one write per cycle |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| lpTick | input | 1 | One-cycle pulses of the slow low-power tick, synchronous to `clk` |
| expiryFlag | output | 1 | Latched fault/expiry flag (bit 14) |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
Two collisions matter. The first is a refresh landing on the very count step that would expire the timer. The second is a flag-clear write landing on the cycle in which an expiry sets the flag. To provoke the first, the bench spaces refreshes exactly timeout+1 clocks apart, so every refresh meets an expiry step. To provoke the second, it places the clear write at that same distance after a refresh. A behavioural reference model judges both, checking each cycle that no reset request appears in the first case and that the flag survives in the second.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // register addresses
  localparam logic [1:0] REG_CS  = 2'd0;
  localparam logic [1:0] REG_CNT = 2'd1;
  localparam logic [1:0] REG_TMO = 2'd2;
  localparam logic [1:0] REG_WIN = 2'd3;

  // control/status bit positions (software decodes these)
  localparam int CS_UPD = 5;
  localparam int CS_EN  = 7;
  localparam int CS_SEL = 8;
  localparam int CS_RCS = 10;
  localparam int CS_ULK = 11;
  localparam int CS_C32 = 13;
  localparam int CS_FLG = 14;

  // command words
  localparam logic [31:0] UNLOCK32  = 32'hD928_C520;
  localparam logic [31:0] REFRESH32 = 32'hB480_A602;
  localparam logic [15:0] UNL_W0    = 16'hC520;
  localparam logic [15:0] UNL_W1    = 16'hD928;
  localparam logic [15:0] REF_W0    = 16'hA602;
  localparam logic [15:0] REF_W1    = 16'hB480;

  typedef enum logic [1:0] {PEND_NONE, PEND_UNL, PEND_REF} pendKind_t;

  // control -> datapath
  typedef struct packed {
    logic tick;       // count step this cycle
    logic armed;      // counting enabled
    logic refresh;    // accepted refresh command
    logic restart;    // configuration applied
    logic wrTimeout;
    logic wrWindow;
  } wdStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic expire;
    logic early;
  } wdEvent_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TMO_RST = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        st,
  input  logic [CNT_W-1:0] wrVal,
  output wdEvent_t         ev,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] tmoVal,
  output logic [CNT_W-1:0] winVal
);

  localparam logic [CNT_W-1:0] TMO_INIT = CNT_W'(TMO_RST);

  logic [CNT_W-1:0] countQ, tmoQ, winQ;
  logic tmoHit;

  always_comb begin
    tmoHit    = st.tick && (countQ == tmoQ);
    ev.early  = st.refresh && st.armed && (winQ != '0) && (countQ < winQ);
    ev.expire = tmoHit && !st.refresh && !st.restart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      tmoQ   <= TMO_INIT;
      winQ   <= '0;
    end else begin
      if (st.refresh || st.restart || ev.expire) countQ <= '0;
      else if (st.tick)                          countQ <= countQ + 1'b1;
      if (st.wrTimeout) tmoQ <= wrVal;
      if (st.wrWindow)  winQ <= wrVal;
    end
  end

  assign countVal = countQ;
  assign tmoVal   = tmoQ;
  assign winVal   = winQ;

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int UNLOCK_WIN = 255,
  parameter int SEQ_GAP    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  input  logic        lpTick,
  input  wdEvent_t    ev,
  output wdStrobe_t   st,
  output logic [31:0] csRead,
  output logic        unlocked,
  output logic        resetReq,
  output logic        flag
);

  localparam int UW = $clog2(UNLOCK_WIN + 1);
  localparam int GW = $clog2(SEQ_GAP + 1);

  logic          enable, updAllow, cmdWide, cfgDone;
  logic [1:0]    clkSel;
  logic [UW-1:0] unlockTimer;
  logic [GW-1:0] pendGap;
  pendKind_t     pendKind;

  logic        cntWr, csWr, pendLive, unlockCmd, refreshCmd, csApply;
  logic        badUnlock, goodUnlock, faultNow;
  logic [15:0] loWord;

  // command decode
  always_comb begin
    cntWr    = wrEn && (addr == REG_CNT);
    csWr     = wrEn && (addr == REG_CS);
    loWord   = wdata[15:0];
    pendLive = (pendGap != '0);
    unlocked = (unlockTimer != '0);
    if (cmdWide) begin
      unlockCmd  = cntWr && (wdata == UNLOCK32);
      refreshCmd = cntWr && (wdata == REFRESH32);
    end else begin
      unlockCmd  = cntWr && pendLive && (pendKind == PEND_UNL) && (loWord == UNL_W1);
      refreshCmd = cntWr && pendLive && (pendKind == PEND_REF) && (loWord == REF_W1);
    end
    goodUnlock = unlockCmd && updAllow;
    badUnlock  = unlockCmd && !updAllow;
    csApply    = csWr && unlocked;
    faultNow   = ev.expire || ev.early || badUnlock;
  end

  // strobes to the datapath
  always_comb begin
    st.tick      = enable && ((clkSel == 2'd0) || lpTick);
    st.armed     = enable;
    st.refresh   = refreshCmd;
    st.restart   = csApply;
    st.wrTimeout = wrEn && (addr == REG_TMO) && unlocked;
    st.wrWindow  = wrEn && (addr == REG_WIN) && unlocked;
  end

  // 16-bit pair tracking
  always_ff @(posedge clk) begin
    if (!rstN || cmdWide) begin
      pendGap  <= '0;
      pendKind <= PEND_NONE;
    end else if (cntWr) begin
      if (unlockCmd || refreshCmd) begin
        pendGap  <= '0;
        pendKind <= PEND_NONE;
      end else if (loWord == UNL_W0) begin
        pendGap  <= GW'(SEQ_GAP);
        pendKind <= PEND_UNL;
      end else if (loWord == REF_W0) begin
        pendGap  <= GW'(SEQ_GAP);
        pendKind <= PEND_REF;
      end else begin
        pendGap  <= '0;
        pendKind <= PEND_NONE;
      end
    end else if (pendLive) begin
      pendGap <= pendGap - 1'b1;
    end
  end

  // configuration, window and status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable      <= 1'b0;
      updAllow    <= 1'b1;
      cmdWide     <= 1'b1;
      clkSel      <= 2'd0;
      cfgDone     <= 1'b0;
      unlockTimer <= '0;
      flag        <= 1'b0;
      resetReq    <= 1'b0;
    end else begin
      if (goodUnlock)    unlockTimer <= UW'(UNLOCK_WIN);
      else if (csApply)  unlockTimer <= '0;
      else if (unlocked) unlockTimer <= unlockTimer - 1'b1;

      if (goodUnlock)   cfgDone <= 1'b0;
      else if (csApply) cfgDone <= 1'b1;

      if (csApply) begin
        enable   <= wdata[CS_EN];
        updAllow <= wdata[CS_UPD];
        cmdWide  <= wdata[CS_C32];
        clkSel   <= wdata[CS_SEL +: 2];
      end

      if (faultNow)                   flag <= 1'b1;
      else if (csWr && wdata[CS_FLG]) flag <= 1'b0;

      resetReq <= faultNow;
    end
  end

  always_comb begin
    csRead                = '0;
    csRead[CS_UPD]        = updAllow;
    csRead[CS_EN]         = enable;
    csRead[CS_SEL +: 2]   = clkSel;
    csRead[CS_RCS]        = cfgDone;
    csRead[CS_ULK]        = unlocked;
    csRead[CS_C32]        = cmdWide;
    csRead[CS_FLG]        = flag;
  end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TMO_RST    = 1000,
  parameter int UNLOCK_WIN = 255,
  parameter int SEQ_GAP    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        lpTick,
  output logic        expiryFlag,
  output logic        resetReq
);

  wdStrobe_t        st;
  wdEvent_t         ev;
  logic [31:0]      csRead;
  logic             unlocked;
  logic [CNT_W-1:0] countVal, tmoVal, winVal;

  wdt_ctrl #(.UNLOCK_WIN(UNLOCK_WIN), .SEQ_GAP(SEQ_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .lpTick(lpTick), .ev(ev), .st(st), .csRead(csRead),
    .unlocked(unlocked), .resetReq(resetReq), .flag(expiryFlag)
  );

  wdt_datapath #(.CNT_W(CNT_W), .TMO_RST(TMO_RST)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wrVal(wdata[CNT_W-1:0]),
    .ev(ev), .countVal(countVal), .tmoVal(tmoVal), .winVal(winVal)
  );

  always_comb begin
    case (addr)
      REG_CS:  rdata = csRead;
      REG_CNT: rdata = 32'(countVal);
      REG_TMO: rdata = 32'(tmoVal);
      default: rdata = 32'(winVal);
    endcase
  end

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       addr,
  input logic [31:0]      wdata,
  input logic             resetReq,
  input logic             expiryFlag,
  input logic             unlocked,
  input logic [31:0]      csRead,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] tmoVal
);

  // R11: a reset request always comes with the flag set
  a_r11_flag_with_req: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> expiryFlag);

  // R5: an applied configuration reports done and closes the window
  a_r5_cfg_closes: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && wrEn && addr == 2'd0) |=> (csRead[10] && !unlocked));

  // R4: timeout register holds while locked
  a_r4_tmo_locked: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && wrEn && addr == 2'd2) |=> (tmoVal == $past(tmoVal)));

  // R2: a 32-bit refresh clears the counter
  a_r2_refresh_clears: assert property (@(posedge clk) disable iff (!rstN)
    (csRead[13] && wrEn && addr == 2'd1 && wdata == 32'hB480_A602) |=> (countVal == '0));

  // R10: unlock with updates barred faults and stays locked
  a_r10_bad_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (csRead[13] && !csRead[5] && wrEn && addr == 2'd1 && wdata == 32'hD928_C520)
      |=> (resetReq && !unlocked));

endmodule

bind wdt_core wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
  .resetReq(resetReq), .expiryFlag(expiryFlag), .unlocked(unlocked),
  .csRead(csRead), .countVal(countVal), .tmoVal(tmoVal)
);

// File: tb/tb_wdt_core.sv
module tb_wdt_core;

  localparam int CLK_PERIOD = 10;
  localparam int TMO_DEF    = 1000;

  localparam logic [31:0] EN   = 32'h0000_0080;
  localparam logic [31:0] UPD  = 32'h0000_0020;
  localparam logic [31:0] SEL1 = 32'h0000_0100;
  localparam logic [31:0] C32  = 32'h0000_2000;
  localparam logic [31:0] FLG  = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic        lpTick = 1'b0;
  logic [31:0] rdata;
  logic        expiryFlag, resetReq;

  int checks = 0;
  int fails  = 0;
  bit running = 0;
  bit finished = 0;

  wdt_core dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lpTick(lpTick), .expiryFlag(expiryFlag), .resetReq(resetReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int mCount, mTmo, mWin, mUnl, mGap, mKind, mSel;
  bit mEn, mUpd, mC32, mFlag, mRcs, mRst;

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    logic [31:0] v;
    case (a)
      2'd0: v = (32'(mUpd) << 5) | (32'(mEn) << 7) | (32'(mSel) << 8) | (32'(mRcs) << 10)
              | (32'(mUnl > 0) << 11) | (32'(mC32) << 13) | (32'(mFlag) << 14);
      2'd1: v = 32'(mCount);
      2'd2: v = 32'(mTmo);
      default: v = 32'(mWin);
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    bit tick, isCnt, unl, rf, csOk, early, expd, bad, fault;
    int nGap, nKind;
    if (!rstN) begin
      mCount = 0; mTmo = TMO_DEF; mWin = 0; mUnl = 0; mGap = 0; mKind = 0; mSel = 0;
      mEn = 0; mUpd = 1; mC32 = 1; mFlag = 0; mRcs = 0; mRst = 0;
    end else begin
      tick  = mEn && (mSel == 0 || lpTick);
      isCnt = wrEn && addr == 2'd1;
      unl = 0; rf = 0;
      nGap = (mGap > 0) ? mGap - 1 : 0;
      nKind = mKind;
      if (mC32) begin
        unl = isCnt && wdata == 32'hD928C520;
        rf  = isCnt && wdata == 32'hB480A602;
        nGap = 0; nKind = 0;
      end else if (isCnt) begin
        if (mGap > 0 && mKind == 1 && wdata[15:0] == 16'hD928) unl = 1;
        if (mGap > 0 && mKind == 2 && wdata[15:0] == 16'hB480) rf = 1;
        if (unl || rf) begin nGap = 0; nKind = 0; end
        else if (wdata[15:0] == 16'hC520) begin nGap = 16; nKind = 1; end
        else if (wdata[15:0] == 16'hA602) begin nGap = 16; nKind = 2; end
        else begin nGap = 0; nKind = 0; end
      end
      csOk  = wrEn && addr == 2'd0 && mUnl > 0;
      early = rf && mEn && mWin != 0 && mCount < mWin;
      expd  = tick && mCount == mTmo && !rf && !csOk;
      bad   = unl && !mUpd;
      fault = early || expd || bad;
      if (rf || csOk || expd) mCount = 0;
      else if (tick) mCount = (mCount + 1) % 65536;
      if (wrEn && addr == 2'd2 && mUnl > 0) mTmo = int'(wdata[15:0]);
      if (wrEn && addr == 2'd3 && mUnl > 0) mWin = int'(wdata[15:0]);
      if (fault) mFlag = 1;
      else if (wrEn && addr == 2'd0 && wdata[14]) mFlag = 0;
      if (unl && mUpd) begin mUnl = 255; mRcs = 0; end
      else if (csOk) begin
        mUnl = 0; mRcs = 1;
        mEn = wdata[7]; mUpd = wdata[5]; mC32 = wdata[13]; mSel = int'(wdata[9:8]);
      end else if (mUnl > 0) mUnl = mUnl - 1;
      mGap = nGap; mKind = nKind;
      mRst = fault;
    end
  end

  // per-cycle comparison of the registered outputs
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (resetReq !== mRst) begin
        fails++;
        $display("FAIL R8/R9/R10/R12 resetReq at %0t: actual %0b expected %0b", $time, resetReq, mRst);
      end
      checks++;
      if (expiryFlag !== mFlag) begin
        fails++;
        $display("FAIL R11 expiryFlag at %0t: actual %0b expected %0b", $time, expiryFlag, mFlag);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    logic [31:0] exp;
    addr = a;
    #1;
    exp = modelRead(a);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s read addr %0d: actual %h expected %h", req, a, rdata, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1;
    // R1 reset values, R13 address map
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1"); rd(2'd3, "R1");
    checks++;
    if (rdata !== 32'd0 || modelRead(2'd0) !== 32'h2020 || dut.rdata === 32'hx) begin
      // self-consistency of the spec constants
      if (modelRead(2'd0) !== 32'h2020) begin
        fails++; $display("FAIL R1 model reset: actual %h expected %h", modelRead(2'd0), 32'h2020);
      end
    end
    // R4 writes while locked are ignored
    wr(2'd0, EN | UPD | C32); rd(2'd0, "R4");
    wr(2'd2, 32'd5);          rd(2'd2, "R4");
    // R2 32-bit unlock, R5/R6 configuration
    wr(2'd1, 32'hD928C520);   rd(2'd0, "R2");
    wr(2'd2, 32'd20); wr(2'd3, 32'd0);
    wr(2'd0, EN | UPD | C32); rd(2'd0, "R5");
    idle(5);                  rd(2'd1, "R7");
    idle(30);                 rd(2'd0, "R8");
    // R11 flag clear while locked
    wr(2'd0, FLG | EN);       rd(2'd0, "R11");
    // R2 refresh keeps it alive
    for (int i = 0; i < 5; i++) begin
      idle(10); wr(2'd1, 32'hB480A602); rd(2'd1, "R2");
    end
    // R12 refresh exactly on the expiry step
    wr(2'd1, 32'hB480A602);
    for (int i = 0; i < 4; i++) begin
      idle(20); wr(2'd1, 32'hB480A602);
    end
    rd(2'd1, "R12"); rd(2'd0, "R12");
    // R11 flag clear colliding with expiry: set wins
    wr(2'd1, 32'hB480A602); idle(20); wr(2'd0, FLG);
    rd(2'd0, "R11");
    wr(2'd0, FLG);            rd(2'd0, "R11");
    // R3 16-bit commands
    wr(2'd1, 32'hD928C520); wr(2'd0, EN | UPD); rd(2'd0, "R3");
    wr(2'd1, 32'h0000A602); idle(15); wr(2'd1, 32'h0000B480); rd(2'd1, "R3");
    wr(2'd1, 32'h0000A602); idle(16); wr(2'd1, 32'h0000B480); rd(2'd1, "R3");
    wr(2'd1, 32'h0000A602); wr(2'd1, 32'h00001234); wr(2'd1, 32'h0000B480); rd(2'd1, "R3");
    wr(2'd1, 32'h0000A602); wr(2'd1, 32'h0000A602); wr(2'd1, 32'hFFFFB480); rd(2'd1, "R3");
    wr(2'd1, 32'hD928C520); rd(2'd0, "R3");
    wr(2'd1, 32'h0000C520); wr(2'd1, 32'h0000D928); rd(2'd0, "R3");
    // R9 windowed refresh
    wr(2'd3, 32'd10); wr(2'd0, EN | UPD | FLG); rd(2'd3, "R9");
    wr(2'd1, 32'h0000A602); wr(2'd1, 32'h0000B480); rd(2'd0, "R9");
    idle(11); wr(2'd1, 32'h0000A602); wr(2'd1, 32'h0000B480); rd(2'd1, "R9");
    // R4 unlock window runs out
    wr(2'd1, 32'h0000C520); wr(2'd1, 32'h0000D928); rd(2'd0, "R4");
    idle(260); rd(2'd0, "R4");
    wr(2'd2, 32'd7); rd(2'd2, "R4");
    // R7 low-power tick source
    wr(2'd1, 32'h0000C520); wr(2'd1, 32'h0000D928);
    wr(2'd3, 32'd0); wr(2'd0, EN | UPD | C32 | SEL1 | FLG);
    idle(10); rd(2'd1, "R7");
    for (int i = 0; i < 30; i++) begin
      lpTick = (i % 2 == 0); @(negedge clk);
    end
    lpTick = 1'b0;
    rd(2'd1, "R7"); rd(2'd0, "R7");
    for (int i = 0; i < 20; i++) begin
      lpTick = 1'b1; @(negedge clk);
    end
    lpTick = 1'b0;
    rd(2'd1, "R8");
    // R10 unlock with updates barred
    wr(2'd1, 32'hD928C520); wr(2'd0, EN | C32 | FLG); rd(2'd0, "R6");
    wr(2'd1, 32'hD928C520); rd(2'd0, "R10");
    idle(2); rd(2'd0, "R10");
    idle(3);
    running = 0;
    finish();
  end

endmodule